// File: doc/BRIEF.md
# Stereo SRAM delay line controller

This block keeps a circular stereo delay buffer in an external asynchronous SRAM with 16-bit words. Each audio frame is started by a one-cycle strobe. The block latches the dry left/right sample pair and writes both samples into the SRAM. It also reads back the pair stored a chosen number of addresses behind the write position and presents that pair as the wet output. A one-cycle valid pulse marks the end of the frame.

Left and right samples occupy consecutive SRAM addresses. At the start of a frame the write and read pointers each step by one. The left read comes first, and the read pointer then steps. The left write follows. Next comes the right read, after which the write pointer steps, and the right write ends the data phase. At the close of the frame the read pointer is rebuilt as the write pointer minus the delay input. An even delay of D addresses therefore gives D/2 frames of delay. All pointer arithmetic wraps at the size of the address space, so the buffer is circular.

Top module: `stereo_sram_delay`

## Requirements
- R1: After reset, CE, WE and OE are all high (inactive), the data bus is not driven, both wet outputs are zero and the valid pulse is low.
- R2: A strobe seen while idle starts one frame that ends with exactly one single-cycle valid pulse. A strobe that arrives while a frame is in progress is ignored.
- R3: With an even delay D of at least 2, the wet pair delivered in frame f equals the dry pair from frame f-D/2. Before that frame exists, the wet pair is whatever the SRAM held at those addresses.
- R4: With a delay of 1, the wet left sample is the dry right sample of the previous frame, and the wet right sample is the dry left sample of the current frame.
- R5: Pointers wrap modulo 2^ADDR_W, so delays near the full buffer size keep working after the write pointer wraps.
- R6: A read holds OE low and WE high with a stable address for SETTLE cycles, and the data is sampled at the end of the last of those cycles. Each frame performs exactly two reads.
- R7: A write drives WE low for one cycle with the sample on the bus. The data stays driven and the address stays stable as WE rises. Each frame writes the left sample first and then the right sample.
- R8: The block drives the data bus only while OE is high. It releases the bus the cycle after each write, so no read ever sees contention.
- R9: After reset the first frame stores its left sample at address 1 and its right sample at address 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_i | input | 1 | Frame start strobe |
| dry_l_i | input | DW | Dry left sample |
| dry_r_i | input | DW | Dry right sample |
| delay_i | input | AW | Delay in SRAM addresses (two per frame) |
| wet_l_o | output | DW | Delayed left sample |
| wet_r_o | output | DW | Delayed right sample |
| wet_valid_o | output | 1 | One-cycle pulse at frame end |
| sram_addr_o | output | AW | SRAM address |
| sram_dq_io | inout | DW | SRAM data bus |
| sram_ce_n_o | output | 1 | SRAM chip enable, active low |
| sram_we_n_o | output | 1 | SRAM write enable, active low |
| sram_oe_n_o | output | 1 | SRAM output enable, active low |

## Verification
The bench builds the block with ADDR_W=8 and SETTLE=2, backed by a 256-word behavioural SRAM. The small address space makes the write pointer wrap after 128 frames, so a delay of 254 addresses (127 frames) runs across several wraps within a short simulation. Both the odd delay of 1 and the even delays fill and then read back the buffer. The pin activity of each frame is counted to confirm the read settle window and the write pulses.

// File: rtl/sdl_pkg.sv
package sdl_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_ADV,
    S_RD,
    S_WSU,
    S_WPW,
    S_WHD,
    S_FIN
  } seq_e;
endpackage

// File: rtl/sdl_ptr_unit.sv
module sdl_ptr_unit #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          rd_inc,
  input  logic          wr_inc,
  input  logic          rebase,
  input  logic [AW-1:0] delay_i,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr
);
  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return p + AW'(1);
  endfunction

  function automatic logic [AW-1:0] behind(input logic [AW-1:0] w, input logic [AW-1:0] d);
    return w - d;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (adv) begin
        wr_ptr <= step(wr_ptr);
        rd_ptr <= step(rd_ptr);
      end else if (rd_inc) begin
        rd_ptr <= step(rd_ptr);
      end else if (wr_inc) begin
        wr_ptr <= step(wr_ptr);
      end else if (rebase) begin
        rd_ptr <= behind(wr_ptr, delay_i);
      end
    end
  end

  AST_WR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && (wr_ptr == '1)) |=> (wr_ptr == '0)); // R5
  AST_REBASE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    rebase |=> ((wr_ptr - rd_ptr) == $past(delay_i))); // R3
endmodule

// File: rtl/sdl_sequencer.sv
module sdl_sequencer
  import sdl_pkg::*;
#(
  parameter int SETTLE = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_i,
  output seq_e state,
  output logic ch,
  output logic accept,
  output logic adv,
  output logic rd_inc,
  output logic wr_inc,
  output logic rebase,
  output logic cap_l,
  output logic cap_r
);
  localparam int CW = $clog2(SETTLE + 1);

  seq_e          nxt;
  logic [CW-1:0] cnt;
  logic          rd_last;

  assign rd_last = (state == S_RD) && (cnt == CW'(SETTLE - 1));
  assign accept  = (state == S_IDLE) && frame_i;
  assign adv     = (state == S_ADV);
  assign rd_inc  = rd_last && !ch;
  assign wr_inc  = rd_last && ch;
  assign cap_l   = rd_last && !ch;
  assign cap_r   = rd_last && ch;
  assign rebase  = (state == S_FIN);

  always_comb begin
    nxt = state;
    unique case (state)
      S_IDLE: if (frame_i) nxt = S_ADV;
      S_ADV:  nxt = S_RD;
      S_RD:   if (rd_last) nxt = S_WSU;
      S_WSU:  nxt = S_WPW;
      S_WPW:  nxt = S_WHD;
      S_WHD:  nxt = ch ? S_FIN : S_RD;
      S_FIN:  nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cnt   <= '0;
      ch    <= 1'b0;
    end else begin
      state <= nxt;
      if (state == S_RD && !rd_last) cnt <= cnt + CW'(1);
      else cnt <= '0;
      if (state == S_ADV) ch <= 1'b0;
      else if (state == S_WHD) ch <= 1'b1;
    end
  end

  AST_IGNORE_BUSY_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    ((state != S_IDLE) && frame_i) |=> (state != S_ADV)); // R2
  AST_READ_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) != S_RD && state == S_RD && SETTLE > 1) |=> (state == S_RD)); // R6
endmodule

// File: rtl/sdl_sram_pins.sv
module sdl_sram_pins
  import sdl_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  seq_e          state,
  input  logic          ch,
  input  logic [AW-1:0] wr_ptr,
  input  logic [AW-1:0] rd_ptr,
  input  logic [DW-1:0] lat_l,
  input  logic [DW-1:0] lat_r,
  output logic [AW-1:0] addr,
  output logic          ce_n,
  output logic          we_n,
  output logic          oe_n,
  output logic          dq_oe,
  output logic [DW-1:0] dq_out
);
  logic in_write;

  assign in_write = (state == S_WSU) || (state == S_WPW) || (state == S_WHD);
  assign addr     = in_write ? wr_ptr : rd_ptr;
  assign ce_n     = (state == S_IDLE);
  assign oe_n     = (state != S_RD);
  assign we_n     = (state != S_WPW);
  assign dq_oe    = (state == S_WPW) || (state == S_WHD);
  assign dq_out   = ch ? lat_r : lat_l;
endmodule

// File: rtl/stereo_sram_delay.sv
module stereo_sram_delay
  import sdl_pkg::*;
#(
  parameter int AW     = 16,
  parameter int DW     = 16,
  parameter int SETTLE = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_i,
  input  logic [DW-1:0] dry_l_i,
  input  logic [DW-1:0] dry_r_i,
  input  logic [AW-1:0] delay_i,
  output logic [DW-1:0] wet_l_o,
  output logic [DW-1:0] wet_r_o,
  output logic          wet_valid_o,
  output logic [AW-1:0] sram_addr_o,
  inout  wire  [DW-1:0] sram_dq_io,
  output logic          sram_ce_n_o,
  output logic          sram_we_n_o,
  output logic          sram_oe_n_o
);
  seq_e          state;
  logic          ch, accept, adv, rd_inc, wr_inc, rebase, cap_l, cap_r;
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [DW-1:0] lat_l, lat_r, dq_out;
  logic          dq_oe;

  sdl_sequencer #(.SETTLE(SETTLE)) u_seq (
    .clk(clk), .rst_n(rst_n), .frame_i(frame_i), .state(state), .ch(ch),
    .accept(accept), .adv(adv), .rd_inc(rd_inc), .wr_inc(wr_inc),
    .rebase(rebase), .cap_l(cap_l), .cap_r(cap_r)
  );

  sdl_ptr_unit #(.AW(AW)) u_ptr (
    .clk(clk), .rst_n(rst_n), .adv(adv), .rd_inc(rd_inc), .wr_inc(wr_inc),
    .rebase(rebase), .delay_i(delay_i), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr)
  );

  sdl_sram_pins #(.AW(AW), .DW(DW)) u_pins (
    .state(state), .ch(ch), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
    .lat_l(lat_l), .lat_r(lat_r), .addr(sram_addr_o), .ce_n(sram_ce_n_o),
    .we_n(sram_we_n_o), .oe_n(sram_oe_n_o), .dq_oe(dq_oe), .dq_out(dq_out)
  );

  assign sram_dq_io  = dq_oe ? dq_out : 'z;
  assign wet_valid_o = rebase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_l   <= '0;
      lat_r   <= '0;
      wet_l_o <= '0;
      wet_r_o <= '0;
    end else begin
      if (accept) begin
        lat_l <= dry_l_i;
        lat_r <= dry_r_i;
      end
      if (cap_l) wet_l_o <= sram_dq_io;
      if (cap_r) wet_r_o <= sram_dq_io;
    end
  end

  AST_READ_WE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_oe_n_o |-> sram_we_n_o); // R6
  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> sram_oe_n_o); // R8
  AST_DATA_AT_WE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n_o) |-> dq_oe); // R7
  AST_ADDR_HELD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n_o |=> $stable(sram_addr_o)); // R7
  AST_BUS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe && sram_we_n_o) |=> !dq_oe); // R8
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wet_valid_o |=> !wet_valid_o); // R2
endmodule

// File: tb/sim_stereo_sram_delay.sv
module sim_stereo_sram_delay;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int SETTLE = 2;
  localparam int NV = 5;
  localparam int VDLY [NV] = '{2, 4, 6, 1, 254};
  localparam int VNFR [NV] = '{10, 12, 14, 10, 300};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_i = 1'b0;
  logic [DW-1:0] dry_l = '0, dry_r = '0;
  logic [AW-1:0] delay = '0;
  logic [DW-1:0] wet_l, wet_r;
  logic wet_valid;
  logic [AW-1:0] addr;
  wire  [DW-1:0] dq;
  logic ce_n, we_n, oe_n;

  logic [DW-1:0] mem [2**AW];
  int checks = 0, fails = 0, cyc = 0;
  int oe_cnt, we_cnt, xcnt;
  logic [DW-1:0] wdat [2];
  logic [DW-1:0] hl [400], hr [400];

  always #2.5 clk = ~clk;

  stereo_sram_delay #(.AW(AW), .DW(DW), .SETTLE(SETTLE)) u0 (
    .clk(clk), .rst_n(rst_n), .frame_i(frame_i), .dry_l_i(dry_l), .dry_r_i(dry_r),
    .delay_i(delay), .wet_l_o(wet_l), .wet_r_o(wet_r), .wet_valid_o(wet_valid),
    .sram_addr_o(addr), .sram_dq_io(dq), .sram_ce_n_o(ce_n),
    .sram_we_n_o(we_n), .sram_oe_n_o(oe_n)
  );

  assign dq = (ce_n === 1'b0 && oe_n === 1'b0 && we_n === 1'b1) ? mem[addr] : 'z;
  always @(posedge we_n) if (ce_n === 1'b0) mem[addr] = dq;

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: actual cycles %0d expected < 150000", cyc);
      summary();
    end
  end

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 2**AW; i++) mem[i] = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_frame(input logic [DW-1:0] l, input logic [DW-1:0] r,
                          output logic [DW-1:0] wl, output logic [DW-1:0] wr);
    int n;
    @(negedge clk);
    dry_l = l; dry_r = r; frame_i = 1'b1;
    @(negedge clk);
    frame_i = 1'b0;
    oe_cnt = 0; we_cnt = 0; xcnt = 0; n = 0;
    while (wet_valid !== 1'b1 && n < 60) begin
      if (oe_n === 1'b0) begin
        oe_cnt++;
        if ((^dq) === 1'bx) xcnt++;
      end
      if (we_n === 1'b0) begin
        if (we_cnt < 2) wdat[we_cnt] = dq;
        we_cnt++;
      end
      @(negedge clk);
      n++;
    end
    wl = wet_l; wr = wet_r;
  endtask

  task automatic run_seg(input int d, input int nf, input int s);
    logic [DW-1:0] wl, wr, el, er;
    int k;
    delay = AW'(d);
    clear_mem();
    do_reset();
    k = d / 2;
    for (int f = 0; f < nf; f++) begin
      hl[f] = DW'(s * 4099 + f * 31 + 7);
      hr[f] = DW'(s * 577 + f * 97 + 1001);
      do_frame(hl[f], hr[f], wl, wr);
      if (d % 2 == 1) begin
        el = (f == 0) ? '0 : hr[f-1];
        er = (f == 0) ? '0 : hl[f];
        check("R4 wet left", wl, el);
        check("R4 wet right", wr, er);
      end else begin
        el = (f < k) ? '0 : hl[f-k];
        er = (f < k) ? '0 : hr[f-k];
        if (d > 200) begin
          check("R5 wrap wet left", wl, el);
          check("R5 wrap wet right", wr, er);
        end else begin
          check("R3 wet left", wl, el);
          check("R3 wet right", wr, er);
        end
      end
      if (s == 0 && f == 0) begin
        check("R9 left at addr 1", mem[1], hl[0]);
        check("R9 right at addr 2", mem[2], hr[0]);
        check("R6 oe low cycles", DW'(oe_cnt), DW'(2 * SETTLE));
        check("R7 we pulses", DW'(we_cnt), DW'(2));
        check("R7 first write data", wdat[0], hl[0]);
        check("R7 second write data", wdat[1], hr[0]);
        check("R8 contention cycles", DW'(xcnt), DW'(0));
      end
    end
  endtask

  initial begin
    int nval;
    do_reset();
    check("R1 ce_n", DW'(ce_n), DW'(1));
    check("R1 we_n", DW'(we_n), DW'(1));
    check("R1 oe_n", DW'(oe_n), DW'(1));
    check("R1 dq released", ((dq === 'z) ? DW'(1) : DW'(0)), DW'(1));
    check("R1 wet left", wet_l, '0);
    check("R1 wet right", wet_r, '0);
    check("R1 valid", DW'(wet_valid), DW'(0));

    for (int s = 0; s < NV; s++) run_seg(VDLY[s], VNFR[s], s);

    // R8: bus idle between frames
    @(negedge clk);
    check("R8 dq released when idle", ((dq === 'z) ? DW'(1) : DW'(0)), DW'(1));

    // R2: second strobe inside a frame is ignored
    delay = AW'(2);
    do_reset();
    @(negedge clk);
    frame_i = 1'b1;
    @(negedge clk);
    frame_i = 1'b0;
    repeat (2) @(negedge clk);
    frame_i = 1'b1;
    @(negedge clk);
    frame_i = 1'b0;
    nval = 0;
    for (int i = 0; i < 40; i++) begin
      if (wet_valid === 1'b1) nval++;
      @(negedge clk);
    end
    check("R2 one valid per accepted strobe", DW'(nval), DW'(1));

    summary();
  end
endmodule